// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block produces the bus cycles a CPU core runs when it accepts an interrupt or a trap. It handles six sources. Four are hardware sources: a reset request, an abort, a non-maskable request and a maskable request. Two are software traps: break and co-processor. The block is idle until one of them is pending. It then picks the winner by a fixed priority and snapshots the core's context: the emulation flag, the program counter, the program bank, the stack pointer, the status byte and the captured address of the aborted opcode. It then runs one entry sequence with one bus cycle per clock.

Every cycle drives a 24-bit address, a write-data byte, the read/write line and four status strobes: opcode-fetch sync, valid data address, valid program address and vector pull (active low). The sequence starts with two lead-in cycles. It then pushes the return context onto the stack, reads the two vector bytes from bank 0 and finishes with a one-cycle done pulse. During that pulse the new program counter, bank, status byte and stack pointer are presented to the core. Emulation mode and native mode differ in three ways: the number of cycles, the pushed status byte and the vector map.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst_n` is released with no request pending, `busy` and `done` are 0, `rwb` and `vp` are 1, `sync`, `vda` and `vpa` are 0, and `addr` is 0.
- R2: A hardware entry starts with two reads at `{pb, pc}`. The first has `sync`, `vda`, `vpa` and `vp` all high. The second has only `rwb` and `vp` high.
- R3: A software trap starts with a read at `{pb, pc-2}` with `sync`, `vda`, `vpa` and `vp` high. This is followed by a read at `{pb, pc-1}` with `vpa` and `vp` high and `sync` and `vda` low.
- R4: The context is pushed in the order bank, PC high byte, PC low byte, status. Each push is a write to `{0x00, S}` with `vda` high and `vpa` and `sync` low, and S drops by one after each push.
- R5: In emulation mode the bank push is skipped, so the entry takes 7 bus cycles. In native mode it takes 8.
- R6: For an abort, the pushed PC is `abort_pc` rather than `pc_in`.
- R7: For a reset entry, `rwb` stays high on all push cycles.
- R8: For a hardware source in emulation mode, bit 4 of the pushed status is 0. In every other case the status is pushed unchanged.
- R9: The two vector reads (low byte, then high byte) drive `vp` low, `vda` high, `vpa` and `sync` low. The vector low byte sits at bank 0 at the address below; the high byte is at the next address. In emulation mode: abort FFF8, co-processor FFF4, NMI FFFA, reset FFFC, IRQ and break FFFE. In native mode: abort FFE8, break FFE6, co-processor FFE4, IRQ FFEE, NMI FFEA, reset FFFC. After the entry, the new status has D (bit 3) cleared and I (bit 2) set, and the new bank is 0x00.
- R10: Priority among pending sources, highest first: reset, abort, NMI, IRQ, break, co-processor.
- R11: A falling edge on `nmi_n` latches an NMI request, and taking the NMI clears it. Holding `nmi_n` low does not start a second entry. An edge that arrives during another entry is taken after that entry ends.
- R12: `irq_n` low starts an IRQ entry only while bit 2 of `p_in` is 0. While that bit is set, the request is ignored.
- R13: `done` is high for exactly one cycle, the cycle after the vector high read. In that cycle `new_pc` equals {high vector byte, low vector byte}, and `new_sp` equals S minus the number of pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| emu | input | 1 | Emulation mode flag |
| pc_in | input | 16 | Current program counter (return address) |
| pb_in | input | 8 | Current program bank |
| sp_in | input | 16 | Current stack pointer |
| p_in | input | 8 | Current status byte (bit 2 = I, bit 3 = D) |
| abort_pc | input | 16 | Address of the aborted opcode |
| res_req | input | 1 | Reset entry request |
| abt_req | input | 1 | Abort request |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active-low level |
| brk_req | input | 1 | Break trap request |
| cop_req | input | 1 | Co-processor trap request |
| rdata | input | 8 | Read data from the bus |
| addr | output | 24 | Bus address |
| wdata | output | 8 | Bus write data |
| rwb | output | 1 | 1 = read, 0 = write |
| sync | output | 1 | Opcode fetch strobe |
| vda | output | 1 | Valid data address |
| vpa | output | 1 | Valid program address |
| vp | output | 1 | Vector pull, active low |
| busy | output | 1 | High during the entry bus cycles |
| done | output | 1 | One-cycle pulse marking the end of the entry |
| new_pc | output | 16 | Loaded program counter |
| new_pb | output | 8 | Loaded program bank |
| new_p | output | 8 | Loaded status byte |
| new_sp | output | 16 | Stack pointer after the pushes |

## Verification
Each of the six sources is run once in each mode with directed values. This separates the hardware lead-in from the software lead-in, shows the 7-cycle and 8-cycle lengths, and shows the two vector maps. Random context values across random sources and modes show that every pushed byte and every stack address follows the snapshot and not a fixed value. Combined requests check the priority chain, and a masked IRQ checks that the mask works. NMI tests use an edge during a running entry and an input held low, which tells edge latching apart from level sensing. The bus memory model returns a byte derived from the address, so a wrong vector address shows up as a wrong `new_pc`.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        emu,
  input  logic [15:0] pc_in,
  input  logic [7:0]  pb_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  p_in,
  input  logic [15:0] abort_pc,
  input  logic        res_req,
  input  logic        abt_req,
  input  logic        nmi_n,
  input  logic        irq_n,
  input  logic        brk_req,
  input  logic        cop_req,
  input  logic [7:0]  rdata,
  output logic [23:0] addr,
  output logic [7:0]  wdata,
  output logic        rwb,
  output logic        sync,
  output logic        vda,
  output logic        vpa,
  output logic        vp,
  output logic        busy,
  output logic        done,
  output logic [15:0] new_pc,
  output logic [7:0]  new_pb,
  output logic [7:0]  new_p,
  output logic [15:0] new_sp
);
  localparam logic [2:0] SRC_RES = 3'd0, SRC_ABT = 3'd1, SRC_NMI = 3'd2,
                         SRC_IRQ = 3'd3, SRC_BRK = 3'd4, SRC_COP = 3'd5;

  logic [3:0]  step;
  logic [2:0]  src, win;
  logic        s_emu, nmi_q, nmi_pend;
  logic [15:0] s_pc, s_sp, s_apc, pc_r, vec;
  logic [7:0]  s_pb, s_p, vec_lo;

  wire irq_ok  = !irq_n && !p_in[2];
  wire any_req = res_req | abt_req | nmi_pend | irq_ok | brk_req | cop_req;
  wire hw      = (src <= SRC_IRQ);
  wire [15:0] push_pc = (src == SRC_ABT) ? s_apc : s_pc;
  wire [15:0] pc_m1   = s_pc - 16'd1;
  wire [15:0] pc_m2   = s_pc - 16'd2;
  wire [7:0]  push_p  = (s_emu && hw) ? (s_p & 8'hEF) : s_p;

  always_comb begin
    win = SRC_COP;
    if (res_req)       win = SRC_RES;
    else if (abt_req)  win = SRC_ABT;
    else if (nmi_pend) win = SRC_NMI;
    else if (irq_ok)   win = SRC_IRQ;
    else if (brk_req)  win = SRC_BRK;
  end

  always_comb begin
    case (src)
      SRC_RES: vec = 16'hFFFC;
      SRC_ABT: vec = s_emu ? 16'hFFF8 : 16'hFFE8;
      SRC_NMI: vec = s_emu ? 16'hFFFA : 16'hFFEA;
      SRC_IRQ: vec = s_emu ? 16'hFFFE : 16'hFFEE;
      SRC_BRK: vec = s_emu ? 16'hFFFE : 16'hFFE6;
      default: vec = s_emu ? 16'hFFF4 : 16'hFFE4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 4'd0; src <= SRC_RES; s_emu <= 1'b0;
      s_pc <= '0; s_sp <= '0; s_apc <= '0; s_pb <= '0; s_p <= '0;
      vec_lo <= '0; pc_r <= '0; nmi_q <= 1'b1; nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_n;
      if (nmi_q && !nmi_n)                    nmi_pend <= 1'b1;
      else if (step == 4'd0 && any_req && win == SRC_NMI) nmi_pend <= 1'b0;
      case (step)
        4'd0: if (any_req) begin
          src <= win; s_emu <= emu; s_pc <= pc_in; s_pb <= pb_in;
          s_sp <= sp_in; s_p <= p_in; s_apc <= abort_pc; step <= 4'd1;
        end
        4'd2: step <= s_emu ? 4'd4 : 4'd3;
        4'd3, 4'd4, 4'd5, 4'd6: begin
          s_sp <= s_sp - 16'd1;
          step <= step + 4'd1;
        end
        4'd7: begin
          vec_lo <= rdata;
          s_p    <= (s_p & 8'hF7) | 8'h04;
          s_pb   <= 8'h00;
          step   <= 4'd8;
        end
        4'd8: begin
          pc_r <= {rdata, vec_lo};
          step <= 4'd9;
        end
        4'd9:    step <= 4'd0;
        default: step <= step + 4'd1;
      endcase
    end
  end

  always_comb begin
    addr = '0; wdata = '0; rwb = 1'b1; sync = 1'b0; vda = 1'b0; vpa = 1'b0; vp = 1'b1;
    case (step)
      4'd1: begin
        addr = {s_pb, hw ? s_pc : pc_m2};
        sync = 1'b1; vda = 1'b1; vpa = 1'b1;
      end
      4'd2: begin
        addr = {s_pb, hw ? s_pc : pc_m1};
        vpa  = !hw;
      end
      4'd3, 4'd4, 4'd5, 4'd6: begin
        addr = {8'h00, s_sp};
        rwb  = (src == SRC_RES);
        vda  = 1'b1;
        case (step)
          4'd3:    wdata = s_pb;
          4'd4:    wdata = push_pc[15:8];
          4'd5:    wdata = push_pc[7:0];
          default: wdata = push_p;
        endcase
      end
      4'd7: begin addr = {8'h00, vec};               vda = 1'b1; vp = 1'b0; end
      4'd8: begin addr = {8'h00, vec[15:1], 1'b1};   vda = 1'b1; vp = 1'b0; end
      default: ;
    endcase
  end

  assign busy   = (step != 4'd0) && (step != 4'd9);
  assign done   = (step == 4'd9);
  assign new_pc = pc_r;
  assign new_pb = s_pb;
  assign new_p  = s_p;
  assign new_sp = s_sp;
endmodule

module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] addr,
  input logic        rwb,
  input logic        sync,
  input logic        vda,
  input logic        vpa,
  input logic        vp,
  input logic        busy,
  input logic        done,
  input logic [2:0]  src
);
  // R9
  vec_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vp |-> (vda && rwb && !vpa && !sync && addr[23:16] == 8'h00));
  // R4
  push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rwb |-> (busy && vda && !vpa && !sync && vp && addr[23:16] == 8'h00));
  // R7
  res_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src == 3'd0) |-> rwb);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R13
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  sync_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (vda && vpa && vp && rwb));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic emu = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, abort_pc = '0;
  logic [7:0]  pb_in = '0, p_in = '0, rdata;
  logic res_req = 0, abt_req = 0, nmi_n = 1, irq_n = 1, brk_req = 0, cop_req = 0;
  logic [23:0] addr;
  logic [7:0]  wdata, new_pb, new_p;
  logic rwb, sync, vda, vpa, vp, busy, done;
  logic [15:0] new_pc, new_sp;
  int checks = 0, failures = 0, cyc = 0;

  irq_entry_seq uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rdata = mem(addr);

  function automatic logic [15:0] vec_of(input int s, input logic e);
    case (s)
      0: return 16'hFFFC;
      1: return e ? 16'hFFF8 : 16'hFFE8;
      2: return e ? 16'hFFFA : 16'hFFEA;
      3: return e ? 16'hFFFE : 16'hFFEE;
      4: return e ? 16'hFFFE : 16'hFFE6;
      default: return e ? 16'hFFF4 : 16'hFFE4;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic setup(input logic e, input logic [15:0] pc, input logic [7:0] pb,
                       input logic [15:0] sp, input logic [7:0] p, input logic [15:0] apc);
    emu = e; pc_in = pc; pb_in = pb; sp_in = sp; p_in = p; abort_pc = apc;
  endtask

  task automatic expect_entry(input int s);
    int n = 0;
    logic hw, erw, es, eda, epa, evp;
    logic [15:0] sp, ppc, vec;
    logic [23:0] ea;
    logic [7:0] ewd, ep;
    string tag;
    while (!busy && n < 6) begin @(negedge clk); n++; end
    chk($sformatf("R10 start of source %0d", s), busy, 1'b1);
    hw = (s <= 3); sp = sp_in; ppc = (s == 1) ? abort_pc : pc_in; vec = vec_of(s, emu);
    ep = (emu && hw) ? (p_in & 8'hEF) : p_in;
    for (int k = 1; k <= 8; k++) begin
      if (k == 3 && emu) continue;
      ewd = 8'h00; erw = 1'b1; es = 1'b0; eda = 1'b0; epa = 1'b0; evp = 1'b1;
      case (k)
        1: begin ea = {pb_in, hw ? pc_in : pc_in - 16'd2}; es = 1; eda = 1; epa = 1;
                 tag = hw ? "R2 lead1" : "R3 lead1"; end
        2: begin ea = {pb_in, hw ? pc_in : pc_in - 16'd1}; epa = !hw;
                 tag = hw ? "R2 lead2" : "R3 lead2"; end
        7: begin ea = {8'h00, vec}; eda = 1; evp = 0; tag = "R9 vec lo"; end
        8: begin ea = {8'h00, vec | 16'h0001}; eda = 1; evp = 0; tag = "R9 vec hi"; end
        default: begin
          ea = {8'h00, sp}; eda = 1; erw = (s == 0);
          ewd = (k == 3) ? pb_in : (k == 4) ? ppc[15:8] : (k == 5) ? ppc[7:0] : ep;
          tag = (s == 0) ? "R7 reset push" : (k == 6) ? "R8 status push" :
                (s == 1 && k != 3) ? "R6 abort pc push" : "R4 push";
        end
      endcase
      chk($sformatf("%s src=%0d emu=%0d", tag, s, emu),
          {addr, rwb, sync, vda, vpa, vp}, {ea, erw, es, eda, epa, evp});
      if (!erw) chk($sformatf("%s data src=%0d", tag, s), wdata, ewd);
      if (k >= 3 && k <= 6) sp = sp - 16'd1;
      @(negedge clk);
    end
    chk($sformatf("R5 length / R13 done emu=%0d", emu), {done, busy}, 2'b10);
    chk("R13 new_pc", new_pc, {mem({8'h00, vec | 16'h0001}), mem({8'h00, vec})});
    chk("R13 new_sp", new_sp, sp);
    chk("R9 new_p", new_p, (p_in & 8'hF7) | 8'h04);
    chk("R9 new_pb", new_pb, 8'h00);
    @(negedge clk);
  endtask

  task automatic fire(input int s);
    case (s)
      0: res_req = 1; 1: abt_req = 1; 2: nmi_n = 0;
      3: irq_n = 0;   4: brk_req = 1; default: cop_req = 1;
    endcase
    @(negedge clk);
    res_req = 0; abt_req = 0; brk_req = 0; cop_req = 0; nmi_n = 1; irq_n = 1;
    expect_entry(s);
  endtask

  initial begin
    logic [31:0] r;
    int s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 reset busy/done", {busy, done}, 2'b00);
    chk("R1 reset bus", {addr, rwb, sync, vda, vpa, vp}, {24'h0, 5'b10001});

    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 6; q++) begin
        setup(m[0], 16'h8123 + 16'(q), 8'h7E, 16'h01F0, 8'h39, 16'h4567);
        fire(q);
      end

    // R12 masked IRQ
    setup(1'b0, 16'h2000, 8'h12, 16'h0300, 8'h04, 16'h0);
    irq_n = 0;
    repeat (6) @(negedge clk);
    chk("R12 masked irq ignored", busy, 1'b0);
    irq_n = 1;
    p_in = 8'h00;
    fire(3);

    // R11 held low, no retrigger
    setup(1'b1, 16'h3000, 8'h00, 16'h01FF, 8'hFF, 16'h0);
    nmi_n = 0;
    expect_entry(2);
    repeat (6) @(negedge clk);
    chk("R11 held nmi no retrigger", {busy, done}, 2'b00);
    nmi_n = 1;
    @(negedge clk);

    // R11 edge during another entry
    setup(1'b0, 16'h4000, 8'h05, 16'h0500, 8'h00, 16'h0);
    fork
      begin repeat (4) @(negedge clk); nmi_n = 0; @(negedge clk); nmi_n = 1; end
    join_none
    fire(3);
    expect_entry(2);
    repeat (4) @(negedge clk);
    chk("R11 nmi cleared after taken", busy, 1'b0);

    // R10 priority
    setup(1'b0, 16'h5000, 8'h33, 16'h0600, 8'h00, 16'hABCD);
    res_req = 1; abt_req = 1; brk_req = 1; cop_req = 1; irq_n = 0;
    fire(0);
    abt_req = 1; brk_req = 1; irq_n = 0;
    fire(1);
    brk_req = 1; cop_req = 1;
    fire(3);
    cop_req = 1;
    fire(4);
    nmi_n = 0;
    @(negedge clk);
    irq_n = 0;
    @(negedge clk);
    irq_n = 1; nmi_n = 1;
    expect_entry(2);

    for (int i = 0; i < 40; i++) begin
      r = $urandom;
      s = int'($urandom_range(0, 5));
      setup(r[0], 16'($urandom), r[15:8], 16'($urandom), (s == 3) ? (r[23:16] & 8'hFB) : r[23:16],
            16'($urandom));
      fire(s);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule